// File: doc/BRIEF.md
# Read-sequence command detector for a small nonvolatile SRAM

This block is a 2K x 8 working SRAM paired with a nonvolatile shadow array of the same size, plus the logic that turns special patterns of read accesses into copy operations between the two. Each clock, the bus inputs form one access when the chip select is high. A write stores a byte. A read returns a byte on the next cycle, or zero when output enable is low.

Two six-step address patterns are watched. The reload pattern is fixed. When it completes, the SRAM is first cleared and then filled from the shadow array. The save pattern is set by a parameter. When it completes, the SRAM is copied into the shadow array. Only reads advance a pattern.

While a copy runs, the busy output is high and the memory ignores all accesses. A programmable hold time at the end of each copy models the slow nonvolatile timing.

Top module: `nvsram_cmd_seq`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, busy is 0 and rd_data is 0.
- R2: Access rules when not busy:
  - An access with cs=1 and we=1 stores wr_data at addr.
  - An access with cs=1, we=0 and oe=1 presents the word at addr on rd_data in the following cycle.
  - In every other case rd_data is 0 in the following cycle.
- R3: Six read accesses to 0x000, 0x555, 0x2AA, 0x7FF, 0x0F0 and 0x70E, in that order, start a reload. busy is high in the cycle after the sixth read. The level of oe during these reads makes no difference.
- R4: A write access returns both pattern matchers to their start. A write never counts as a step.
- R5: A read to an address other than the next expected one returns a matcher to its start. If that address is the first address of the pattern, it counts as step one.
- R6: Cycles with cs=0 do not disturb a pattern in progress.
- R7: busy stays high for exactly 2*2048+RECALL_WAIT cycles for a reload, and for 2048+STORE_WAIT cycles for a save.
- R8: While busy is high:
  - writes are not stored;
  - reads return 0;
  - no access advances either pattern.
- R9: After a reload, every SRAM word equals the corresponding shadow word. A reload leaves the shadow array unchanged, so repeated reloads give the same contents.
- R10: Six reads to the STORE_SEQ addresses start a save. STORE_SEQ holds element 0 in its low 11 bits, and defaults to 0x000, 0x555, 0x2AA, 0x7FF, 0x0F0, 0x70F. After the save, the shadow array holds the SRAM contents as they were when the save was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Access in this cycle |
| we | input | 1 | 1 = write access, 0 = read access |
| oe | input | 1 | Read data is presented only when high |
| addr | input | 11 | Word address |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data, one cycle after the read |
| busy | output | 1 | A copy operation is running |

## Verification
The bench fills the whole SRAM, saves it, dirties part of it and reloads. It then reads the memory back, which shows that a save captured the SRAM and that a reload restored the shadow contents rather than the dirtied ones.

The reload pattern is tried in several forms:
- with oe low;
- broken by a write, which must not start an operation;
- broken by a wrong address;
- restarted by a repeated 0x000, which must still start.

The save pattern is spread over idle cycles. During one reload, the bench drives writes, reads and a full reload pattern, to show that busy shuts the memory off completely.

// File: rtl/nvsram_cmd_seq.sv
module nvsram_cmd_seq #(
  parameter int DW = 8,
  parameter int RECALL_WAIT = 16,
  parameter int STORE_WAIT = 64,
  parameter logic [65:0] STORE_SEQ = {11'h70F, 11'h0F0, 11'h7FF, 11'h2AA, 11'h555, 11'h000}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          we,
  input  logic          oe,
  input  logic [10:0]   addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam int MAXW = (RECALL_WAIT > STORE_WAIT) ? RECALL_WAIT : STORE_WAIT;
  localparam int CW = $clog2(MAXW + 1);
  localparam logic [65:0] RECALL_SEQ = {11'h70E, 11'h0F0, 11'h7FF, 11'h2AA, 11'h555, 11'h000};

  typedef enum logic [2:0] {S_IDLE, S_CLEAR, S_LOAD, S_SAVE, S_HOLD} st_t;

  st_t            st;
  logic [AW-1:0]  idx;
  logic [CW-1:0]  cnt;
  logic [2:0]     rstep, sstep;
  logic [DW-1:0]  sram [DEPTH];
  logic [DW-1:0]  nv   [DEPTH];

  assign busy = (st != S_IDLE);

  wire rd = cs && !we && !busy;
  wire wr = cs && we && !busy;

  wire [AW-1:0] rexp = RECALL_SEQ[32'(rstep) * AW +: AW];
  wire [AW-1:0] sexp = STORE_SEQ[32'(sstep) * AW +: AW];
  wire rhit = rd && (addr == rexp);
  wire shit = rd && (addr == sexp);
  wire rdone = rhit && (rstep == 3'd5);
  wire sdone = shit && (sstep == 3'd5) && !rdone;
  wire last = &idx;

  function automatic logic [2:0] advance(logic [2:0] cur, logic hit, logic first);
    if (hit) return cur + 3'd1;
    return first ? 3'd1 : 3'd0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || busy || rdone || sdone || wr) begin
      rstep <= 3'd0;
      sstep <= 3'd0;
    end else if (rd) begin
      rstep <= advance(rstep, rhit, addr == RECALL_SEQ[AW-1:0]);
      sstep <= advance(sstep, shit, addr == STORE_SEQ[AW-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      idx <= '0;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          idx <= '0;
          if (rdone) st <= S_CLEAR;
          else if (sdone) st <= S_SAVE;
        end
        S_CLEAR: begin
          idx <= idx + 1'b1;
          if (last) st <= S_LOAD;
        end
        S_LOAD: begin
          idx <= idx + 1'b1;
          if (last) begin
            st  <= S_HOLD;
            cnt <= CW'(RECALL_WAIT);
          end
        end
        S_SAVE: begin
          idx <= idx + 1'b1;
          if (last) begin
            st  <= S_HOLD;
            cnt <= CW'(STORE_WAIT);
          end
        end
        S_HOLD: begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr) sram[addr] <= wr_data;
    else if (st == S_CLEAR) sram[idx] <= '0;
    else if (st == S_LOAD) sram[idx] <= nv[idx];
  end

  always_ff @(posedge clk) begin
    if (st == S_SAVE) nv[idx] <= sram[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else rd_data <= (rd && oe) ? sram[addr] : '0;
  end

  a_r3_start_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs && !we && (rstep == 3'd5 || sstep == 3'd5)));

  a_r4_write_never_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we) |=> !$rose(busy));

  a_r8_blank_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (rd_data == '0));

  a_r7_exit_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(st == S_HOLD));

  a_r2_no_data_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (rd_data == '0));
endmodule

// File: tb/nvsram_cmd_seq_test.sv
module nvsram_cmd_seq_test;
  localparam int N = 2048;
  localparam int RW = 16;
  localparam int SW = 64;
  localparam logic [10:0] RSEQ [6] = '{11'h000, 11'h555, 11'h2AA, 11'h7FF, 11'h0F0, 11'h70E};
  localparam logic [10:0] SSEQ [6] = '{11'h000, 11'h555, 11'h2AA, 11'h7FF, 11'h0F0, 11'h70F};

  logic clk = 0, rst_n = 0, cs = 0, we = 0, oe = 0;
  logic [10:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic busy;

  int checks = 0, errors = 0;
  string cur = "R1";

  nvsram_cmd_seq uut (.clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .oe(oe),
                      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .busy(busy));

  always #4 clk = ~clk;

  logic [7:0] m_sram [N];
  logic [7:0] m_nv [N];
  logic [7:0] m_rd = '0;
  int bl = 0, rs = 0, ss = 0;

  function automatic int adv(int s, logic [10:0] a, bit rec);
    logic [10:0] e, f;
    e = rec ? RSEQ[s] : SSEQ[s];
    f = rec ? RSEQ[0] : SSEQ[0];
    if (a == e) return s + 1;
    return (a == f) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      bl = 0; rs = 0; ss = 0; m_rd = '0;
    end else if (bl > 0) begin
      bl--; m_rd = '0; rs = 0; ss = 0;
    end else begin
      m_rd = '0;
      if (cs && we) begin
        m_sram[addr] = wr_data; rs = 0; ss = 0;
      end else if (cs) begin
        if (oe) m_rd = m_sram[addr];
        rs = adv(rs, addr, 1'b1);
        ss = adv(ss, addr, 1'b0);
        if (rs == 6) begin
          for (int i = 0; i < N; i++) m_sram[i] = m_nv[i];
          bl = 2 * N + RW; rs = 0; ss = 0;
        end else if (ss == 6) begin
          for (int i = 0; i < N; i++) m_nv[i] = m_sram[i];
          bl = N + SW; rs = 0; ss = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    checks += 2;
    if (busy !== (bl > 0)) begin
      errors++;
      $display("FAIL %s busy: actual %0b expected %0b at %0t", cur, busy, bl > 0, $time);
    end
    if (rd_data !== m_rd) begin
      errors++;
      $display("FAIL %s rd_data: actual %02h expected %02h at %0t", cur, rd_data, m_rd, $time);
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(bit c, bit w, bit o, logic [10:0] a, logic [7:0] d);
    cs = c; we = w; oe = o; addr = a; wr_data = d;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, '0);
  endtask

  task automatic run_seq(bit rec, bit o, int gap);
    for (int i = 0; i < 6; i++) begin
      cyc(1, 0, o, rec ? RSEQ[i] : SSEQ[i], '0);
      if (i < 5) idle(gap);
    end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin
      n++;
      cyc(0, 0, 0, '0, '0);
    end
  endtask

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  int n;

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(busy === 1'b0 && rd_data === 8'h00, "R1 reset outputs", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0 && rd_data === 8'h00, "R1 after reset", int'(rd_data), 0);

    cur = "R2";
    for (int i = 0; i < N; i++) cyc(1, 1, 0, 11'(i), pat(i));
    cyc(1, 0, 1, 11'h123, '0);
    chk(rd_data === pat('h123), "R2 read word", int'(rd_data), int'(pat('h123)));
    cyc(1, 0, 0, 11'h124, '0);
    chk(rd_data === 8'h00, "R2 oe low gives zero", int'(rd_data), 0);

    cur = "R10";
    run_seq(1'b0, 1'b1, 0);
    count_busy(n);
    chk(n == N + SW, "R7 save busy length", n, N + SW);

    cur = "R9";
    for (int i = 0; i < 32; i++) cyc(1, 1, 0, 11'(i), 8'hAA);
    cyc(1, 0, 1, 11'd3, '0);
    chk(rd_data === 8'hAA, "R2 dirtied word", int'(rd_data), 'hAA);

    cur = "R3";
    run_seq(1'b1, 1'b0, 0);
    chk(busy === 1'b1, "R3 reload starts with oe low", int'(busy), 1);
    cur = "R8";
    n = 0;
    while (busy) begin
      n++;
      if (n == 10) cyc(1, 1, 0, 11'd5, 8'h11);
      else if (n == 11) cyc(1, 0, 1, 11'd5, '0);
      else if (n >= 12 && n < 18) cyc(1, 0, 1, RSEQ[n-12], '0);
      else cyc(0, 0, 0, '0, '0);
    end
    chk(n == 2 * N + RW, "R7 reload busy length", n, 2 * N + RW);
    cyc(1, 0, 1, 11'd5, '0);
    chk(rd_data === pat(5), "R8 write during busy ignored", int'(rd_data), int'(pat(5)));
    cyc(0, 0, 0, '0, '0);
    chk(busy === 1'b0, "R8 pattern during busy ignored", int'(busy), 0);

    cur = "R9";
    for (int i = 0; i < 64; i++) cyc(1, 0, 1, 11'(i), '0);
    cyc(1, 0, 1, 11'd17, '0);
    chk(rd_data === pat(17), "R9 reload restores shadow", int'(rd_data), int'(pat(17)));

    cur = "R4";
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, RSEQ[i], '0);
    cyc(1, 1, 0, 11'd40, 8'h5C);
    for (int i = 3; i < 6; i++) cyc(1, 0, 1, RSEQ[i], '0);
    chk(busy === 1'b0, "R4 write breaks pattern", int'(busy), 0);

    cur = "R5";
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, RSEQ[i], '0);
    cyc(1, 0, 1, 11'h100, '0);
    for (int i = 3; i < 6; i++) cyc(1, 0, 1, RSEQ[i], '0);
    chk(busy === 1'b0, "R5 wrong address breaks pattern", int'(busy), 0);
    cyc(1, 0, 1, 11'h000, '0);
    cyc(1, 0, 1, 11'h555, '0);
    run_seq(1'b1, 1'b1, 0);
    chk(busy === 1'b1, "R5 repeated first address restarts", int'(busy), 1);
    count_busy(n);
    cyc(1, 0, 1, 11'd40, '0);
    chk(rd_data === pat(40), "R9 repeat reload same contents", int'(rd_data), int'(pat(40)));

    cur = "R6";
    cyc(1, 1, 0, 11'd7, 8'h3C);
    run_seq(1'b0, 1'b0, 3);
    chk(busy === 1'b1, "R6 idle gaps keep save pattern", int'(busy), 1);
    count_busy(n);
    cur = "R10";
    cyc(1, 1, 0, 11'd7, 8'h00);
    run_seq(1'b1, 1'b1, 0);
    count_busy(n);
    cyc(1, 0, 1, 11'd7, '0);
    chk(rd_data === 8'h3C, "R10 save captured new word", int'(rd_data), 'h3C);
    for (int i = 0; i < 64; i++) cyc(1, 0, 1, 11'(N - 1 - i), '0);
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule